// File: doc/BRIEF.md
# Reconfigurable Fault-Detecting Prefix Adder

This block is a purely combinational 16-bit adder. It is built on a prefix fabric that holds every node any regular radix-2, fan-out-2 topology could need. Every node has an enable bit in a configuration word. A disabled node passes the group value of its own column straight through and ignores its cross-column operand. One netlist can therefore behave as a Kogge-Stone, Brent-Kung or Han-Carlson adder, or as another legal sparse arrangement. The fabric has a forward stage set with spans 1, 2, 4 and 8, followed by a reverse stage set with spans 4, 2 and 1. The reverse set fills in prefixes that sparse forward patterns leave open.

Carry-in is merged into column 0 before the tree. Every final column value is then a complete carry. A checker rebuilds each carry from the operand bits of its column and the primary carry one column down. It XORs that against the tree carry to form a per-bit error signature. A fault-injection port can force the generate output of any one node. This lets the detection path be exercised. Package `rpa_pkg` offers a per-node lookup, `cfg_bit`, that yields the configuration words for the three named topologies.

Top module: `rpa_adder`

## Requirements
- R1: Configuration bit `t*16+i` enables the node of stage `t` at column `i`. Stages 0..3 are forward with span `2^t` and stages 4..6 are reverse with spans 4, 2, 1. A node at column `i` exists only for `i >= span` and combines column `i` (high) with column `i-span` (low). With the Kogge-Stone word (every existing forward node on, every reverse node off), `{cout_o,sum_o}` equals `a_i + b_i + cin_i`.
- R2: With the Brent-Kung word, `{cout_o,sum_o}` equals `a_i + b_i + cin_i`. In that word, forward node (span s, column i) is on when `(i+1) mod 2s == 0`, and reverse node (span s, column i) is on when `i mod 2s == s-1` and `i >= 2s`.
- R3: With the Han-Carlson word, `{cout_o,sum_o}` equals `a_i + b_i + cin_i`. In that word, forward nodes are on at odd columns `i >= span`, and only the span-1 reverse nodes at even columns `i >= 2` are on.
- R4: Carry-in enters as part of the column-0 group. `sum_o[0]` always equals `a_i[0] ^ b_i[0] ^ cin_i`, and `cin_i = 1` adds exactly one to the result.
- R5: A disabled node forwards its own column unchanged. With an all-zero configuration, the carry out of bit 0 is `g0 | p0&cin` and the carry out of bit `i >= 1` is `a_i[i] & b_i[i]`. `sum_o[i] = p_i ^ carry(i-1)` and `cout_o` is the carry out of bit 15.
- R6: Adding 0x0001 to 0xFFFF with carry-in 0 gives sum 0x0000 and carry-out 1 under each of the three named words.
- R7: With fault injection off and any of the three named words, `err_o` is zero.
- R8: `err_o[i]` equals `c_i XOR (g_i | p_i & c_{i-1})`, where `c_i` is the tree carry out of bit `i` and `c_{-1}` is `cin_i`. This holds for any configuration, including illegal ones.
- R9: With `flt_en_i = 1`, the generate output of the node at stage `flt_stage_i` and column `flt_col_i` is forced to `flt_val_i`. Whenever that makes `{cout_o,sum_o}` differ from `a_i + b_i + cin_i`, `err_o` is nonzero.
- R10: With `flt_en_i = 0`, the values on `flt_stage_i`, `flt_col_i` and `flt_val_i` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry-in |
| cfg_i | input | 112 | Node enable word, bit `t*16+i` for stage `t`, column `i` |
| flt_en_i | input | 1 | Enables the forced node value |
| flt_stage_i | input | 3 | Stage of the node to force (0..6) |
| flt_col_i | input | 4 | Column of the node to force |
| flt_val_i | input | 1 | Value forced onto that node's generate output |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry-out |
| err_o | output | 16 | Per-bit error signature |

## Verification
The bench drives the full-length carry chain (0x0001 + 0xFFFF and 0xFFFF + carry-in) through each named word. A wrong span or a missing reverse node would drop the carry partway and leave high sum bits set. An all-zero word checks both the pass-through path and the checker's formula against a bench model. A bypass that took the cross-column operand, or a checker fed by the wrong neighbour, shows up there as wrong sum or signature bits. Random forced-node faults check that every corrupted result raises the signature. A directed stuck-at-1 on the last forward stage pins the exact signature bit. A checker that compared against the wrong column would miss these cases.

// File: rtl/rpa_pkg.sv
package rpa_pkg;

  typedef enum logic [1:0] {
    TOPO_KOGGE  = 2'd0,
    TOPO_BRENT  = 2'd1,
    TOPO_HAN    = 2'd2,
    TOPO_BYPASS = 2'd3
  } topo_e;

  // Span of stage t in a fabric with lg forward stages (lg-1 reverse stages follow).
  function automatic int unsigned stage_span(int unsigned t, int unsigned lg);
    if (t < lg) return 32'd1 << t;
    return 32'd1 << (2 * lg - 2 - t);
  endfunction

  // Enable value of node (stage t, column col) for a named topology.
  function automatic logic cfg_bit(topo_e topo, int unsigned lg, int unsigned t,
                                   int unsigned col);
    int unsigned sp;
    logic        fwd;
    sp  = stage_span(t, lg);
    fwd = (t < lg);
    if (col < sp) return 1'b0;
    case (topo)
      TOPO_KOGGE: return fwd;
      TOPO_BRENT: begin
        if (fwd) return ((col + 1) % (2 * sp)) == 0;
        return (((col + 1) % (2 * sp)) == sp) && (col >= 2 * sp);
      end
      TOPO_HAN: begin
        if (fwd) return col[0];
        return (sp == 1) && !col[0];
      end
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rpa_setup.sv
module rpa_setup #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] g_bit_o,
  output logic [N-1:0] p_bit_o,
  output logic [N-1:0] g_col_o,
  output logic [N-1:0] p_col_o
);

  assign g_bit_o = a_i & b_i;
  assign p_bit_o = a_i ^ b_i;

  // Column 0 absorbs carry-in: its group reaches below bit 0, so its propagate is zero.
  always_comb begin
    g_col_o    = g_bit_o;
    p_col_o    = p_bit_o;
    g_col_o[0] = g_bit_o[0] | (p_bit_o[0] & cin_i);
    p_col_o[0] = 1'b0;
  end

endmodule

// File: rtl/rpa_prefix_stage.sv
module rpa_prefix_stage #(
  parameter  int unsigned N    = 16,
  parameter  int unsigned SPAN = 1,
  localparam int unsigned CW   = $clog2(N)
) (
  input  logic [N-1:0]  g_in,
  input  logic [N-1:0]  p_in,
  input  logic [N-1:0]  en,
  input  logic          flt_hit,
  input  logic [CW-1:0] flt_col,
  input  logic          flt_val,
  output logic [N-1:0]  g_out,
  output logic [N-1:0]  p_out
);

  logic [N-1:0] g_mux;
  logic [N-1:0] p_mux;

  for (genvar i = 0; i < N; i++) begin : g_col
    if (i >= SPAN) begin : g_node
      logic g_dot;
      logic p_dot;
      // high operand is this column, low operand is SPAN columns down
      assign g_dot    = g_in[i] | (p_in[i] & g_in[i-SPAN]);
      assign p_dot    = p_in[i] & p_in[i-SPAN];
      assign g_mux[i] = en[i] ? g_dot : g_in[i];
      assign p_mux[i] = en[i] ? p_dot : p_in[i];
    end else begin : g_pass
      logic unused_en;
      assign unused_en = en[i];
      assign g_mux[i]  = g_in[i];
      assign p_mux[i]  = p_in[i];
    end
  end

  always_comb begin
    g_out = g_mux;
    p_out = p_mux;
    if (flt_hit) g_out[flt_col] = flt_val;
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (!(flt_hit && (flt_col == CW'(i)))) begin
        // R5
        g_grow_chk: assert (!(g_in[i] && !g_out[i]))
          else $error("stage cleared generate of its own column %0d", i);
      end
      // R5
      p_shrink_chk: assert (!(p_out[i] && !p_in[i]))
        else $error("stage raised propagate of column %0d", i);
    end
  end

endmodule

// File: rtl/rpa_sum_check.sv
module rpa_sum_check #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] g_bit_i,
  input  logic [N-1:0] p_bit_i,
  input  logic         cin_i,
  input  logic [N-1:0] c_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o,
  output logic [N-1:0] err_o
);

  logic [N-1:0] c_below;
  logic [N-1:0] c_rebuilt;

  assign c_below   = {c_i[N-2:0], cin_i};
  assign sum_o     = p_bit_i ^ c_below;
  assign cout_o    = c_i[N-1];
  // one redundant prefix step per bit, fed by the primary carry underneath
  assign c_rebuilt = g_bit_i | (p_bit_i & c_below);
  assign err_o     = c_i ^ c_rebuilt;

endmodule

// File: rtl/rpa_adder.sv
module rpa_adder #(
  parameter  int unsigned N     = 16,
  localparam int unsigned LG    = $clog2(N),
  localparam int unsigned STG   = 2 * LG - 1,
  localparam int unsigned CFG_W = STG * N,
  localparam int unsigned SW    = $clog2(STG),
  localparam int unsigned CW    = $clog2(N)
) (
  input  logic [N-1:0]     a_i,
  input  logic [N-1:0]     b_i,
  input  logic             cin_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             flt_en_i,
  input  logic [SW-1:0]    flt_stage_i,
  input  logic [CW-1:0]    flt_col_i,
  input  logic             flt_val_i,
  output logic [N-1:0]     sum_o,
  output logic             cout_o,
  output logic [N-1:0]     err_o
);

  logic [N-1:0] g_bit;
  logic [N-1:0] p_bit;
  logic [N-1:0] g_lvl [STG+1];
  logic [N-1:0] p_lvl [STG+1];

  rpa_setup #(.N(N)) setup_i (
    .a_i     (a_i),
    .b_i     (b_i),
    .cin_i   (cin_i),
    .g_bit_o (g_bit),
    .p_bit_o (p_bit),
    .g_col_o (g_lvl[0]),
    .p_col_o (p_lvl[0])
  );

  for (genvar t = 0; t < STG; t++) begin : g_stage
    localparam int unsigned SPAN = rpa_pkg::stage_span(t, LG);
    logic hit;
    assign hit = flt_en_i && (flt_stage_i == SW'(t));
    rpa_prefix_stage #(.N(N), .SPAN(SPAN)) stage_i (
      .g_in    (g_lvl[t]),
      .p_in    (p_lvl[t]),
      .en      (cfg_i[t*N +: N]),
      .flt_hit (hit),
      .flt_col (flt_col_i),
      .flt_val (flt_val_i),
      .g_out   (g_lvl[t+1]),
      .p_out   (p_lvl[t+1])
    );
  end

  logic unused_p_final;
  assign unused_p_final = ^p_lvl[STG];

  rpa_sum_check #(.N(N)) check_i (
    .g_bit_i (g_bit),
    .p_bit_i (p_bit),
    .cin_i   (cin_i),
    .c_i     (g_lvl[STG]),
    .sum_o   (sum_o),
    .cout_o  (cout_o),
    .err_o   (err_o)
  );

  logic [N:0] ref_total;
  assign ref_total = {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i};

  always_comb begin
    if (err_o == '0) begin
      // R9
      clean_sig_sum_chk: assert ({cout_o, sum_o} == ref_total)
        else $error("clean signature but wrong result");
    end
    // R4
    lsb_cin_chk: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ cin_i))
      else $error("bit 0 sum ignores carry-in");
  end

endmodule

// File: tb/rpa_adder_tb_top.sv
module rpa_adder_tb_top;

  localparam int N     = 16;
  localparam int LG    = 4;
  localparam int STG   = 7;
  localparam int CFG_W = STG * N;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]     a, b;
  logic             cin;
  logic [CFG_W-1:0] cfg;
  logic             fe;
  logic [2:0]       fs;
  logic [3:0]       fc;
  logic             fv;
  logic [N-1:0]     sum;
  logic             cout;
  logic [N-1:0]     err;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  rpa_adder dut_i (
    .a_i(a), .b_i(b), .cin_i(cin), .cfg_i(cfg),
    .flt_en_i(fe), .flt_stage_i(fs), .flt_col_i(fc), .flt_val_i(fv),
    .sum_o(sum), .cout_o(cout), .err_o(err)
  );

  function automatic logic [CFG_W-1:0] mk_cfg(int kind);
    logic [CFG_W-1:0] v;
    v = '0;
    for (int t = 0; t < STG; t++) begin
      for (int i = 0; i < N; i++) begin
        int sp;
        bit on;
        sp = (t < LG) ? (1 << t) : (1 << (STG - 1 - t));
        on = 1'b0;
        if (i >= sp) begin
          case (kind)
            0: on = (t < LG);
            1: if (t < LG) on = ((i % (2 * sp)) == 2 * sp - 1);
               else        on = ((i % (2 * sp)) == sp - 1) && (i >= 2 * sp);
            2: if (t < LG) on = ((i % 2) == 1);
               else        on = (sp == 1) && ((i % 2) == 0);
            default: on = 1'b0;
          endcase
        end
        v[t*N+i] = on;
      end
    end
    return v;
  endfunction

  function automatic logic [N:0] exp_add(logic [N-1:0] x, logic [N-1:0] y, logic ci);
    return {1'b0, x} + {1'b0, y} + {{N{1'b0}}, ci};
  endfunction

  // {err, cout, sum} for the all-bypass word
  function automatic logic [2*N:0] bypass_model(logic [N-1:0] x, logic [N-1:0] y, logic ci);
    logic [N-1:0] g, p, c, s, r;
    g = x & y;
    p = x ^ y;
    c = g;
    c[0] = g[0] | (p[0] & ci);
    for (int i = 0; i < N; i++) begin
      logic below;
      below = (i == 0) ? ci : c[i-1];
      s[i] = p[i] ^ below;
      r[i] = g[i] | (p[i] & below);
    end
    return {c ^ r, c[N-1], s};
  endfunction

  task automatic apply(logic [N-1:0] x, logic [N-1:0] y, logic ci, logic [CFG_W-1:0] w,
                       logic e, logic [2:0] st, logic [3:0] co, logic va);
    @(posedge clk);
    #1;
    a = x; b = y; cin = ci; cfg = w; fe = e; fs = st; fc = co; fv = va;
    @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    string tags[3];
    logic [N:0] e17;
    logic [2*N:0] bm;
    void'($urandom(32'h1234_5eed));
    tags[0] = "R1"; tags[1] = "R2"; tags[2] = "R3";
    a = '0; b = '0; cin = 0; cfg = '0; fe = 0; fs = '0; fc = '0; fv = 0;

    // idle state: zero operands under Kogge-Stone word
    apply('0, '0, 0, mk_cfg(0), 0, 0, 0, 0);
    check({cout, sum} == '0, "R1 zero operands", {cout, sum}, 0);
    check(err == '0, "R7 zero operands", err, 0);

    for (int k = 0; k < 3; k++) begin
      apply(16'h0001, 16'hFFFF, 0, mk_cfg(k), 0, 0, 0, 0);
      check({cout, sum} == 17'h10000, {"R6 chain ", tags[k]}, {cout, sum}, 17'h10000);
      check(err == '0, {"R7 chain ", tags[k]}, err, 0);
      apply(16'hFFFF, 16'h0000, 1, mk_cfg(k), 0, 0, 0, 0);
      check({cout, sum} == 17'h10000, {"R4 cin chain ", tags[k]}, {cout, sum}, 17'h10000);
      apply(16'h8000, 16'h8000, 0, mk_cfg(k), 0, 0, 0, 0);
      check({cout, sum} == 17'h10000, {"R6 top carry ", tags[k]}, {cout, sum}, 17'h10000);
      for (int n = 0; n < 150; n++) begin
        logic [N-1:0] x, y;
        logic ci;
        x = N'($urandom); y = N'($urandom); ci = 1'($urandom);
        apply(x, y, ci, mk_cfg(k), 0, 0, 0, 0);
        e17 = exp_add(x, y, ci);
        check({cout, sum} == e17, {tags[k], " random add"}, {cout, sum}, e17);
        check(err == '0, {"R7 random ", tags[k]}, err, 0);
        check(sum[0] == (x[0] ^ y[0] ^ ci), "R4 bit0", sum[0], x[0] ^ y[0] ^ ci);
      end
    end

    // R10: fault fields wiggled while injection is off
    for (int n = 0; n < 60; n++) begin
      logic [N-1:0] x, y;
      logic ci;
      int k;
      x = N'($urandom); y = N'($urandom); ci = 1'($urandom); k = $urandom % 3;
      apply(x, y, ci, mk_cfg(k), 0, 3'($urandom), 4'($urandom), 1'($urandom));
      e17 = exp_add(x, y, ci);
      check({cout, sum} == e17, "R10 result", {cout, sum}, e17);
      check(err == '0, "R10 signature", err, 0);
    end

    // R5 and R8: all nodes bypassed
    for (int n = 0; n < 100; n++) begin
      logic [N-1:0] x, y;
      logic ci;
      x = N'($urandom); y = N'($urandom); ci = 1'($urandom);
      if (n == 0) begin x = 16'hFFFF; y = 16'h0001; ci = 1; end
      apply(x, y, ci, mk_cfg(3), 0, 0, 0, 0);
      bm = bypass_model(x, y, ci);
      check({cout, sum} == bm[N:0], "R5 bypass result", {cout, sum}, bm[N:0]);
      check(err == bm[2*N:N+1], "R8 bypass signature", err, bm[2*N:N+1]);
    end

    // R8: stuck-at-1 on column 5 of the last forward stage, Kogge-Stone word
    apply('0, '0, 0, mk_cfg(0), 1, 3'd3, 4'd5, 1);
    check({cout, sum} == 17'h00040, "R9 directed fault result", {cout, sum}, 17'h00040);
    check(err == 16'h0020, "R8 directed fault signature", err, 16'h0020);

    // R9: random forced nodes
    for (int n = 0; n < 300; n++) begin
      logic [N-1:0] x, y;
      logic ci;
      int k;
      x = N'($urandom); y = N'($urandom); ci = 1'($urandom); k = $urandom % 3;
      apply(x, y, ci, mk_cfg(k), 1, 3'($urandom % STG), 4'($urandom), 1'($urandom));
      e17 = exp_add(x, y, ci);
      check(({cout, sum} == e17) || (err != '0), "R9 fault escaped",
            {err, cout, sum}, {16'h0, e17});
    end

    done = 1;
    summary();
    $finish;
  end

endmodule